// File: doc/BRIEF.md
# MESI Line State Controller

This block keeps the coherence state of a small, directly indexed set of lines in one private cache. The local processor sends read, write and evict requests. Other caches send snoops, which are remote reads and remote writes. The block updates the 2-bit state of the addressed line and drives three bus actions: a line fill, an invalidate broadcast and a write-back. It answers each local request with a hit or miss flag and the state the line ends in. It answers each snoop with an acknowledge and a flag that tells whether this cache held the line.

A single controller serves one transaction at a time and works through four phases: `C_IDLE`, `C_FILL`, `C_UPGR` and `C_WBACK`. A snoop that hits a dirty line is not acknowledged at once. The controller first writes the line back, which leaves it Exclusive. It then serves the snoop. The requester keeps `snp_valid` high until it sees `snp_ack`.

Top module: `mesi_line_ctrl`

Named transitions:
- `C_IDLE -> C_FILL` on a local miss.
- `C_IDLE -> C_UPGR` on a local write to a Shared line.
- `C_IDLE -> C_WBACK` on an evict of a Modified line, or on a snoop that hits a Modified line.
- `C_FILL -> C_UPGR` on a write miss when the fill reports a sharer.
- `C_FILL`, `C_UPGR` and `C_WBACK` return to `C_IDLE` on `fill_done`, `inv_ack` and `wb_done` respectively.

## Requirements
- R1: Line states are encoded as Invalid=00, Shared=01, Exclusive=10 and Modified=11. After reset every line is Invalid, no bus action is driven, `resp_valid` is low and `req_ready` is high.
- R2: Request codes are 00 read, 01 write, 10 evict and 11 read. A read of a non-Invalid line responds one cycle after acceptance. The response has hit=1 and the unchanged state, and no bus action is raised.
- R3: A read of an Invalid line raises `fill_req` with `bus_idx` set to the line and holds it until `fill_done`. The line then becomes Shared if `fill_shared` is high and Exclusive otherwise. The response, with hit=0, follows one cycle later.
- R4: A remote read (`snp_op`=0) of a Modified line raises `wb_req` and holds `snp_ack` low until `wb_done`. The line then becomes Exclusive. The snoop is acknowledged in the next cycle with `snp_shared`=1, and the line ends Shared.
- R5: A remote read of an Exclusive line moves it to Shared. A remote read of a Shared line leaves it Shared. Both are acknowledged in the same cycle with `snp_shared`=1. A remote read of an Invalid line is acknowledged with `snp_shared`=0 and leaves the line Invalid.
- R6: A local write to an Exclusive line makes it Modified with hit=1 and no bus action. A local write to a Modified line keeps it Modified.
- R7: A local write to a Shared line raises `inv_req` until `inv_ack`. The line then becomes Modified, with hit=1.
- R8: A local write to an Invalid line fills the line first. Without a sharer the line becomes Modified. With a sharer the controller raises `inv_req`, and the line becomes Modified after `inv_ack`. The response carries hit=0.
- R9: A remote write (`snp_op`=1) to a Shared or Exclusive line is acknowledged at once, with `snp_shared`=1, and the line becomes Invalid. A remote write to a Modified line is first written back, which leaves the line Exclusive. It is then acknowledged and the line becomes Invalid.
- R10: An evict of a Modified line raises `wb_req` until `wb_done`. The line then becomes Exclusive, and the response carries hit=1 and state Exclusive. An evict of any other line changes nothing, raises no bus action and reports the current state.
- R11: A pending snoop takes priority: `req_ready` is low while `snp_valid` is high or a transaction is in progress. At most one of `fill_req`, `inv_req` and `wb_req` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | Local request code |
| req_idx | input | IDX_W | Line index of local request |
| req_ready | output | 1 | Local request accepted this cycle when valid |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Line was valid when the request was accepted |
| resp_state | output | 2 | State the line ends in |
| snp_valid | input | 1 | Snoop present, held until acknowledged |
| snp_op | input | 1 | 0 remote read, 1 remote write |
| snp_idx | input | IDX_W | Line index of snoop |
| snp_ack | output | 1 | Snoop served this cycle |
| snp_shared | output | 1 | This cache held the line when the snoop was served |
| fill_req | output | 1 | Line fill request |
| inv_req | output | 1 | Invalidate broadcast request |
| wb_req | output | 1 | Write-back request |
| bus_idx | output | IDX_W | Line index of the current bus action |
| fill_done | input | 1 | Fill completed |
| fill_shared | input | 1 | Another cache holds the filled line |
| inv_ack | input | 1 | Invalidate broadcast acknowledged |
| wb_done | input | 1 | Write-back completed |

## Verification
The bench builds the block with NUM_LINES=4, which gives a 2-bit index. Four lines are enough to park Shared, Exclusive, Modified and Invalid lines side by side, so one line can be disturbed while the bench probes the others with evicts. The default value also reaches every phase, including a write miss that needs both a fill and an invalidate, and snoops of both kinds that must wait for a write-back.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_t;

    typedef enum logic [1:0] {
        C_IDLE,
        C_FILL,
        C_UPGR,
        C_WBACK
    } ctl_t;

    localparam logic [1:0] OP_RD = 2'b00;
    localparam logic [1:0] OP_WR = 2'b01;
    localparam logic [1:0] OP_EV = 2'b10;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       widx,
    input  mesi_t                  wstate,
    input  logic [IDX_W-1:0]       ridx_a,
    output mesi_t                  rstate_a,
    input  logic [IDX_W-1:0]       ridx_b,
    output mesi_t                  rstate_b,
    output logic [2*NUM_LINES-1:0] flat
);

    mesi_t line_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q[g] <= ST_I;
            end else if (we && widx == IDX_W'(g)) begin
                line_q[g] <= wstate;
            end
        end
        assign flat[2*g +: 2] = line_q[g];
    end

    assign rstate_a = line_q[ridx_a];
    assign rstate_b = line_q[ridx_b];

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    output logic             req_ready,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic [1:0]       resp_state,
    input  logic             snp_valid,
    input  logic             snp_op,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_ack,
    output logic             snp_shared,
    output logic             fill_req,
    output logic             inv_req,
    output logic             wb_req,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             fill_done,
    input  logic             fill_shared,
    input  logic             inv_ack,
    input  logic             wb_done
);

    ctl_t             st_q, st_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             wr_q, wr_d;
    logic             loc_q, loc_d;
    logic             hit_q, hit_d;
    logic             rv_q, rv_d;
    logic             rh_q, rh_d;
    mesi_t            rs_q, rs_d;

    logic             ln_we;
    logic [IDX_W-1:0] ln_widx;
    mesi_t            ln_wst;
    mesi_t            snp_line;
    mesi_t            req_line;
    logic [2*NUM_LINES-1:0] lines_flat;

    mesi_line_store #(.NUM_LINES(NUM_LINES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ln_we),
        .widx     (ln_widx),
        .wstate   (ln_wst),
        .ridx_a   (snp_idx),
        .rstate_a (snp_line),
        .ridx_b   (req_idx),
        .rstate_b (req_line),
        .flat     (lines_flat)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= C_IDLE;
            idx_q <= '0;
            wr_q  <= 1'b0;
            loc_q <= 1'b0;
            hit_q <= 1'b0;
            rv_q  <= 1'b0;
            rh_q  <= 1'b0;
            rs_q  <= ST_I;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            wr_q  <= wr_d;
            loc_q <= loc_d;
            hit_q <= hit_d;
            rv_q  <= rv_d;
            rh_q  <= rh_d;
            rs_q  <= rs_d;
        end
    end

    // outputs
    always_comb begin
        fill_req   = (st_q == C_FILL);
        inv_req    = (st_q == C_UPGR);
        wb_req     = (st_q == C_WBACK);
        bus_idx    = idx_q;
        req_ready  = (st_q == C_IDLE) && !snp_valid;
        snp_ack    = (st_q == C_IDLE) && snp_valid && (snp_line != ST_M);
        snp_shared = snp_ack && (snp_line != ST_I);
        resp_valid = rv_q;
        resp_hit   = rh_q;
        resp_state = rs_q;
    end

    // next state and line updates
    always_comb begin
        st_d    = st_q;
        idx_d   = idx_q;
        wr_d    = wr_q;
        loc_d   = loc_q;
        hit_d   = hit_q;
        rv_d    = 1'b0;
        rh_d    = rh_q;
        rs_d    = rs_q;
        ln_we   = 1'b0;
        ln_widx = idx_q;
        ln_wst  = ST_I;
        unique case (st_q)
            C_IDLE: begin
                if (snp_valid) begin
                    if (snp_line == ST_M) begin
                        st_d  = C_WBACK;
                        idx_d = snp_idx;
                        loc_d = 1'b0;
                    end else begin
                        ln_we   = 1'b1;
                        ln_widx = snp_idx;
                        if (snp_op)                 ln_wst = ST_I;
                        else if (snp_line == ST_E)  ln_wst = ST_S;
                        else                        ln_wst = snp_line;
                    end
                end else if (req_valid) begin
                    idx_d   = req_idx;
                    ln_widx = req_idx;
                    hit_d   = (req_line != ST_I);
                    wr_d    = (req_op == OP_WR);
                    loc_d   = 1'b1;
                    unique case (req_op)
                        OP_WR: begin
                            unique case (req_line)
                                ST_M: begin
                                    rv_d = 1'b1; rh_d = 1'b1; rs_d = ST_M;
                                end
                                ST_E: begin
                                    ln_we  = 1'b1;
                                    ln_wst = ST_M;
                                    rv_d = 1'b1; rh_d = 1'b1; rs_d = ST_M;
                                end
                                ST_S: st_d = C_UPGR;
                                ST_I: st_d = C_FILL;
                            endcase
                        end
                        OP_EV: begin
                            if (req_line == ST_M) begin
                                st_d = C_WBACK;
                            end else begin
                                rv_d = 1'b1;
                                rh_d = (req_line != ST_I);
                                rs_d = req_line;
                            end
                        end
                        default: begin
                            if (req_line == ST_I) begin
                                st_d = C_FILL;
                            end else begin
                                rv_d = 1'b1; rh_d = 1'b1; rs_d = req_line;
                            end
                        end
                    endcase
                end
            end
            C_FILL: begin
                if (fill_done) begin
                    ln_we = 1'b1;
                    if (wr_q && fill_shared) begin
                        ln_wst = ST_S;
                        st_d   = C_UPGR;
                    end else begin
                        if (wr_q)             ln_wst = ST_M;
                        else if (fill_shared) ln_wst = ST_S;
                        else                  ln_wst = ST_E;
                        rv_d = 1'b1;
                        rh_d = hit_q;
                        rs_d = ln_wst;
                        st_d = C_IDLE;
                    end
                end
            end
            C_UPGR: begin
                if (inv_ack) begin
                    ln_we  = 1'b1;
                    ln_wst = ST_M;
                    rv_d = 1'b1; rh_d = hit_q; rs_d = ST_M;
                    st_d = C_IDLE;
                end
            end
            C_WBACK: begin
                if (wb_done) begin
                    ln_we  = 1'b1;
                    ln_wst = ST_E;
                    if (loc_q) begin
                        rv_d = 1'b1; rh_d = 1'b1; rs_d = ST_E;
                    end
                    st_d = C_IDLE;
                end
            end
        endcase
    end

endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fill_req,
    input logic                   inv_req,
    input logic                   wb_req,
    input logic                   fill_done,
    input logic                   fill_shared,
    input logic                   inv_ack,
    input logic                   wb_done,
    input logic                   snp_ack,
    input logic                   req_ready,
    input logic                   resp_valid,
    input logic [1:0]             resp_state,
    input logic [IDX_W-1:0]       bus_idx,
    input logic [2*NUM_LINES-1:0] lines_flat
);

    logic [1:0] at_bus;
    assign at_bus = lines_flat[bus_idx*2 +: 2];

    AST_BUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_req, inv_req, wb_req})); // R11

    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req || inv_req || wb_req) |-> !req_ready); // R11

    AST_NO_SNOOP_DURING_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !snp_ack); // R4

    AST_UPGRADE_TO_M: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && inv_ack) |=> (resp_valid && resp_state == 2'b11)); // R7

    AST_WB_LEAVES_E: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && wb_done) |=> (at_bus == 2'b10)); // R10

    AST_LONE_FILL_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_done && !fill_shared) |=> (resp_valid && resp_state[1])); // R3

endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_req    (fill_req),
    .inv_req     (inv_req),
    .wb_req      (wb_req),
    .fill_done   (fill_done),
    .fill_shared (fill_shared),
    .inv_ack     (inv_ack),
    .wb_done     (wb_done),
    .snp_ack     (snp_ack),
    .req_ready   (req_ready),
    .resp_valid  (resp_valid),
    .resp_state  (resp_state),
    .bus_idx     (bus_idx),
    .lines_flat  (lines_flat)
);

// File: tb/test_mesi_line_ctrl.sv
`timescale 1ns/1ps
module test_mesi_line_ctrl;

    localparam int NL = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, snp_valid = 0, snp_op = 0;
    logic [1:0] req_op = 0;
    logic [IW-1:0] req_idx = 0, snp_idx = 0;
    logic fill_done = 0, fill_shared = 0, inv_ack = 0, wb_done = 0;
    logic req_ready, resp_valid, resp_hit, snp_ack, snp_shared;
    logic fill_req, inv_req, wb_req;
    logic [1:0] resp_state;
    logic [IW-1:0] bus_idx;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NL)) i_mesi_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_idx(req_idx), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_state(resp_state),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_idx(snp_idx),
        .snp_ack(snp_ack), .snp_shared(snp_shared),
        .fill_req(fill_req), .inv_req(inv_req), .wb_req(wb_req), .bus_idx(bus_idx),
        .fill_done(fill_done), .fill_shared(fill_shared), .inv_ack(inv_ack), .wb_done(wb_done)
    );

    localparam logic [1:0] I = 2'b00, S = 2'b01, E = 2'b10, M = 2'b11;
    localparam logic [1:0] RD = 2'b00, WR = 2'b01, EV = 2'b10, RD3 = 2'b11;

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic no_bus(input string tag);
        chk({tag, " bus idle"}, {fill_req, inv_req, wb_req}, 0);
    endtask

    task automatic accept(input logic [1:0] op, input int idx, input string tag);
        @(negedge clk);
        req_valid = 1; req_op = op; req_idx = idx[IW-1:0];
        #1 chk({tag, " ready"}, req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        #1;
    endtask

    task automatic check_resp(input bit ehit, input logic [1:0] est, input string tag);
        chk({tag, " resp_valid"}, resp_valid, 1);
        chk({tag, " hit"}, resp_hit, ehit);
        chk({tag, " state"}, resp_state, est);
    endtask

    task automatic req_now(input logic [1:0] op, input int idx, input bit ehit,
                           input logic [1:0] est, input string tag);
        accept(op, idx, tag);
        check_resp(ehit, est, tag);
        no_bus(tag);
        @(negedge clk);
        #1 chk({tag, " pulse"}, resp_valid, 0);
    endtask

    task automatic probe(input int idx, input logic [1:0] est, input string tag);
        req_now(EV, idx, est != I, est, tag);
    endtask

    task automatic req_fill(input logic [1:0] op, input int idx, input bit sh,
                            input logic [1:0] est, input string tag);
        accept(op, idx, tag);
        chk({tag, " fill_req"}, fill_req, 1);
        chk({tag, " bus_idx"}, bus_idx, idx);
        chk({tag, " no early resp"}, resp_valid, 0);
        @(negedge clk);
        #1 chk({tag, " fill held"}, fill_req, 1);
        fill_done = 1; fill_shared = sh;
        @(negedge clk);
        fill_done = 0; fill_shared = 0;
        #1;
        if (op == WR && sh) begin
            chk({tag, " inv_req"}, inv_req, 1);
            chk({tag, " fill dropped"}, fill_req, 0);
            inv_ack = 1;
            @(negedge clk);
            inv_ack = 0;
            #1;
        end
        check_resp(0, est, tag);
        no_bus(tag);
    endtask

    task automatic req_upgrade(input int idx, input string tag);
        accept(WR, idx, tag);
        chk({tag, " inv_req"}, inv_req, 1);
        chk({tag, " bus_idx"}, bus_idx, idx);
        @(negedge clk);
        #1 chk({tag, " inv held"}, inv_req, 1);
        chk({tag, " no early resp"}, resp_valid, 0);
        inv_ack = 1;
        @(negedge clk);
        inv_ack = 0;
        #1 check_resp(1, M, tag);
        no_bus(tag);
    endtask

    task automatic evict_m(input int idx, input string tag);
        accept(EV, idx, tag);
        chk({tag, " wb_req"}, wb_req, 1);
        chk({tag, " bus_idx"}, bus_idx, idx);
        wb_done = 1;
        @(negedge clk);
        wb_done = 0;
        #1 check_resp(1, E, tag);
        no_bus(tag);
    endtask

    task automatic snoop(input logic op, input int idx, input bit esh, input string tag);
        @(negedge clk);
        snp_valid = 1; snp_op = op; snp_idx = idx[IW-1:0];
        #1 chk({tag, " snp_ack"}, snp_ack, 1);
        chk({tag, " snp_shared"}, snp_shared, esh);
        chk({tag, " req blocked"}, req_ready, 0);
        @(negedge clk);
        snp_valid = 0;
    endtask

    task automatic snoop_m(input logic op, input int idx, input string tag);
        @(negedge clk);
        snp_valid = 1; snp_op = op; snp_idx = idx[IW-1:0];
        #1 chk({tag, " held off"}, snp_ack, 0);
        @(negedge clk);
        #1 chk({tag, " wb_req"}, wb_req, 1);
        chk({tag, " bus_idx"}, bus_idx, idx);
        chk({tag, " still held"}, snp_ack, 0);
        @(negedge clk);
        #1 chk({tag, " wb pending"}, snp_ack, 0);
        wb_done = 1;
        @(negedge clk);
        wb_done = 0;
        #1 chk({tag, " wb over"}, wb_req, 0);
        chk({tag, " served"}, snp_ack, 1);
        chk({tag, " shared"}, snp_shared, 1);
        chk({tag, " no local resp"}, resp_valid, 0);
        @(negedge clk);
        snp_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 chk("R1 resp idle in reset", resp_valid, 0);
        rst_n = 1;
        @(negedge clk);
        #1 chk("R1 ready after reset", req_ready, 1);
        no_bus("R1 after reset");
        for (int i = 0; i < NL; i++) probe(i, I, "R1 reset line invalid");

        req_fill(RD, 0, 0, E, "R3 read miss alone");
        req_now(RD, 0, 1, E, "R2 read hit E");
        req_fill(RD, 1, 1, S, "R3 read miss shared");
        req_now(RD3, 1, 1, S, "R2 code 11 reads");

        snoop(0, 0, 1, "R5 remote read E");
        probe(0, S, "R5 E became S");
        snoop(0, 1, 1, "R5 remote read S");
        probe(1, S, "R5 S stays S");
        snoop(0, 2, 0, "R5 remote read I");
        probe(2, I, "R5 I stays I");

        req_upgrade(0, "R7 write to S");
        snoop_m(0, 0, "R4 remote read M");
        probe(0, S, "R4 ends shared");

        req_fill(RD, 2, 0, E, "R3 second fill");
        req_now(WR, 2, 1, M, "R6 write E silent");
        req_now(WR, 2, 1, M, "R6 write M stays");
        evict_m(2, "R10 evict M");
        probe(2, E, "R10 evict E no change");
        probe(1, S, "R10 evict S no change");

        req_fill(WR, 3, 0, M, "R8 write miss alone");
        snoop_m(1, 3, "R9 remote write M");
        probe(3, I, "R9 M ends invalid");
        req_fill(WR, 3, 1, M, "R8 write miss shared");

        snoop(1, 1, 1, "R9 remote write S");
        probe(1, I, "R9 S ends invalid");
        snoop(1, 2, 1, "R9 remote write E");
        probe(2, I, "R9 E ends invalid");
        snoop(1, 1, 0, "R9 remote write I");

        // R11 snoop wins over a simultaneous local request
        @(negedge clk);
        req_valid = 1; req_op = RD; req_idx = 2'd3;
        snp_valid = 1; snp_op = 0; snp_idx = 2'd0;
        #1 chk("R11 req blocked by snoop", req_ready, 0);
        chk("R11 snoop served first", snp_ack, 1);
        chk("R11 snoop shared", snp_shared, 1);
        @(negedge clk);
        snp_valid = 0;
        #1 chk("R11 req ready after snoop", req_ready, 1);
        @(negedge clk);
        req_valid = 0;
        #1 check_resp(1, M, "R11 deferred read");
        probe(0, S, "R11 snooped line");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule